// File: doc/BRIEF.md
# Configurable UART Channel

A single asynchronous serial channel that sits on a simple register bus. Software writes a one-byte configuration word to pick the receive and transmit bit rate from nine fixed rates, the parity mode and an internal loopback path. Characters to send are written into a four-entry transmit queue; received characters collect in a four-entry receive queue that software empties by reading the data register.

All registers are one byte wide and travel on the upper half of the 16-bit data bus (bits 15:8); the lower half reads as zero. A status register reports queue levels, transmitter activity and three sticky error flags (overflow, parity, framing) that are cleared by the act of reading it. A second channel is obtained by instantiating the block again.

Register addresses: 0 is the data register (read pops the receive queue, write pushes the transmit queue), 1 is the configuration register (write only), 2 is the status register (read only). Reads are combinational: `rdata` carries the value in the same cycle as `rd_en`.

Top module: `uart_chan`

## Requirements
- R1: After reset the configuration is all zero (lowest rate, no parity, no loopback), the status register reads 16'h8000 and the tx pin is high.
- R2: Configuration bit 8 set selects rate index 8; otherwise bits 11:9 give rate index 0..7. The sampling tick period is BASE_DIV >> index clock cycles and one bit lasts 16 ticks, for both receive and transmit.
- R3: A frame is a low start bit, eight data bits least significant first, an optional parity bit, and a high stop bit; the receiver samples each bit at its middle.
- R4: Configuration bits 13:12 select parity: 11 odd (total ones including the parity bit is odd), 10 even, 00 and 01 no parity bit. A received parity bit that disagrees sets status bit 13; the character is still stored.
- R5: With configuration bit 14 set the transmit serial stream feeds the receiver, the external rx pin is ignored and the tx pin stays high.
- R6: Status bit 8 is high while the receive queue holds data and bit 9 while it holds 4 characters; reading address 0 returns the oldest character in bits 15:8 with bits 7:0 zero and removes it.
- R7: A character completed while the receive queue is full (and not being read that cycle) is discarded, the queued characters are kept, and status bit 10 is set.
- R8: Status bit 11 is high while a character is being shifted out or waits in the transmit queue; bit 12 is high while the transmit queue holds 4 characters, and a write to address 0 then is dropped.
- R9: A stop bit sampled low sets status bit 14; the character is still stored.
- R10: Reading the status register clears bits 10, 13 and 14 after the read (a new error in the same cycle wins); bit 15 always reads high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data, byte in bits 15:8 |
| rdata | output | 16 | Read data, byte in bits 15:8 |
| tx | output | 1 | Serial transmit pin |
| rx | input | 1 | Serial receive pin |

## Verification
The bench builds the block with DEPTH 4 and BASE_DIV 256, so rate index 8 gives a one-cycle tick and 16-cycle bits, index 6 and 7 give 64- and 32-cycle bits, and index 0 (the reset rate) gives 4096-cycle bits. That keeps a full reset-rate frame, queue overflow, a full transmit queue and randomised frames at three rates with every parity mode and injected parity and stop errors inside the cycle budget.

// File: rtl/uart_chan.sv
module uart_chan #(
  parameter int DEPTH = 4,
  parameter int BASE_DIV = 10416
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        tx,
  input  logic        rx
);
  localparam int AW = $clog2(DEPTH);
  localparam int DW = $clog2(BASE_DIV + 1);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] ONE = (AW+1)'(1);
  localparam logic [1:0] A_DATA = 2'd0, A_CFG = 2'd1, A_STAT = 2'd2;

  logic [7:0] cfg;
  wire wr_data = wr_en && addr == A_DATA;
  wire wr_cfg  = wr_en && addr == A_CFG;
  wire rd_data = rd_en && addr == A_DATA;
  wire rd_stat = rd_en && addr == A_STAT;
  wire unused_bits = ^{wdata[7:0], cfg[7]};

  wire [3:0] idx = cfg[0] ? 4'd8 : {1'b0, cfg[3:1]};
  wire par_en = cfg[5];
  wire par_odd = cfg[4];
  wire lb = cfg[6];

  always_ff @(posedge clk)
    if (!rst_n) cfg <= '0;
    else if (wr_cfg) cfg <= wdata[15:8];

  logic [DW-1:0] tcnt;
  wire [DW-1:0] div = DW'(BASE_DIV >> idx);
  wire tick = tcnt >= div - DW'(1);

  always_ff @(posedge clk)
    if (!rst_n || wr_cfg || tick) tcnt <= '0;
    else tcnt <= tcnt + DW'(1);

  // transmit queue and shifter
  logic [7:0] tmem [DEPTH];
  logic [AW-1:0] twp, trp;
  logic [AW:0] tn;
  logic tact;
  logic [10:0] tsh;
  logic [3:0] tph, tleft;
  wire t_push = wr_data && tn != FULL;
  wire t_pop = !tact && tn != '0;
  wire [7:0] thead = tmem[trp];
  wire tx_line = tact ? tsh[0] : 1'b1;

  always_ff @(posedge clk) if (t_push) tmem[twp] <= wdata[15:8];

  always_ff @(posedge clk)
    if (!rst_n) begin
      twp <= '0; trp <= '0; tn <= '0;
    end else begin
      if (t_push) twp <= twp + AW'(1);
      if (t_pop) trp <= trp + AW'(1);
      tn <= tn + (t_push ? ONE : '0) - (t_pop ? ONE : '0);
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      tact <= 1'b0; tsh <= '1; tph <= '0; tleft <= '0;
    end else if (t_pop) begin
      tact <= 1'b1;
      tph <= '0;
      tsh <= par_en ? {1'b1, ^thead ^ par_odd, thead, 1'b0} : {2'b11, thead, 1'b0};
      tleft <= par_en ? 4'd11 : 4'd10;
    end else if (tact && tick) begin
      tph <= tph + 4'd1;
      if (tph == 4'd15) begin
        tsh <= {1'b1, tsh[10:1]};
        tleft <= tleft - 4'd1;
        if (tleft == 4'd1) tact <= 1'b0;
      end
    end

  assign tx = lb | tx_line;

  // receiver
  logic [1:0] rsync;
  wire rs = rsync[1];
  logic ract, rpar;
  logic [3:0] rph, rbit;
  logic [7:0] rsh;
  wire [3:0] rlast = par_en ? 4'd10 : 4'd9;
  wire rmid = ract && tick && rph == 4'd7;
  wire rdone = rmid && rbit == rlast;
  wire perr_ev = rdone && par_en && (rpar != (^rsh ^ par_odd));
  wire ferr_ev = rdone && !rs;

  always_ff @(posedge clk)
    if (!rst_n) rsync <= 2'b11;
    else rsync <= {rsync[0], lb ? tx_line : rx};

  always_ff @(posedge clk)
    if (!rst_n) begin
      ract <= 1'b0; rph <= '0; rbit <= '0; rsh <= '0; rpar <= 1'b0;
    end else if (!ract) begin
      if (!rs) begin
        ract <= 1'b1; rph <= '0; rbit <= '0;
      end
    end else if (tick) begin
      rph <= rph + 4'd1;
      if (rph == 4'd7) begin
        if (rbit == 4'd0 && rs) ract <= 1'b0;
        else begin
          if (rbit != 4'd0 && rbit < 4'd9) rsh <= {rs, rsh[7:1]};
          if (rbit == 4'd9 && par_en) rpar <= rs;
          if (rbit == rlast) ract <= 1'b0;
          rbit <= rbit + 4'd1;
        end
      end
    end

  // receive queue
  logic [7:0] rmem [DEPTH];
  logic [AW-1:0] rwp, rrp;
  logic [AW:0] rn;
  wire r_pop = rd_data && rn != '0;
  wire r_push = rdone && (rn != FULL || r_pop);
  wire ovf_ev = rdone && rn == FULL && !r_pop;

  always_ff @(posedge clk) if (r_push) rmem[rwp] <= rsh;

  always_ff @(posedge clk)
    if (!rst_n) begin
      rwp <= '0; rrp <= '0; rn <= '0;
    end else begin
      if (r_push) rwp <= rwp + AW'(1);
      if (r_pop) rrp <= rrp + AW'(1);
      rn <= rn + (r_push ? ONE : '0) - (r_pop ? ONE : '0);
    end

  logic ovf, perr, ferr;
  always_ff @(posedge clk)
    if (!rst_n) begin
      ovf <= 1'b0; perr <= 1'b0; ferr <= 1'b0;
    end else begin
      ovf <= ovf_ev | (ovf & !rd_stat);
      perr <= perr_ev | (perr & !rd_stat);
      ferr <= ferr_ev | (ferr & !rd_stat);
    end

  wire [7:0] stat = {1'b1, ferr, perr, tn == FULL, tact | (tn != '0), ovf, rn == FULL, rn != '0};

  always_comb begin
    rdata = '0;
    if (rd_en && addr == A_DATA && rn != '0) rdata = {rmem[rrp], 8'h00};
    else if (rd_en && addr == A_STAT) rdata = {stat, 8'h00};
  end

  a_r7_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(rn) == FULL) else $error("R7 overflow without full queue");
  a_r10_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !rdone |=> !ovf && !perr && !ferr) else $error("R10 sticky flag survived read");
  a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data && tn == FULL && !t_pop |=> tn == FULL) else $error("R8 write into full queue");
  a_r6_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    r_pop && !r_push |=> rn == $past(rn) - ONE) else $error("R6 pop did not remove entry");
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tact) |-> !tx || lb) else $error("R3 frame did not begin low");
  a_r5_loop_high: assert property (@(posedge clk) disable iff (!rst_n)
    lb && tact |-> tx) else $error("R5 pin moved in loopback");
endmodule

// File: tb/sim_uart_chan.sv
module sim_uart_chan;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, rx = 1;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic tx;
  int checks = 0, errs = 0;
  bit done = 0;

  uart_chan #(.DEPTH(4), .BASE_DIV(256)) u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tx(tx), .rx(rx));

  always #10 clk = ~clk;

  function automatic int bitp(int idx); return 16 * (256 >> idx); endfunction
  function automatic logic [15:0] cfgw(int idx, logic [1:0] par, logic lb);
    logic [2:0] r = (idx == 8) ? 3'd0 : 3'(idx);
    return {1'b0, lb, par, r, idx == 8, 8'h00};
  endfunction
  function automatic logic pbit(logic [7:0] d, logic [1:0] par); return ^d ^ par[0]; endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; rd_en = 1; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic send(logic [7:0] d, int idx, logic [1:0] par, logic badp, logic bads);
    int p = bitp(idx);
    @(negedge clk); rx = 0; repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx = d[i]; repeat (p) @(negedge clk); end
    if (par[1]) begin rx = pbit(d, par) ^ badp; repeat (p) @(negedge clk); end
    if (bads) begin rx = 0; repeat (p * 3 / 4) @(negedge clk); end
    rx = 1; repeat (2 * p) @(negedge clk);
  endtask

  task automatic txget(int idx, logic [1:0] par, output logic [7:0] d, output logic ok);
    int p = bitp(idx);
    int w = 0;
    ok = 1; d = 0;
    while (tx !== 1'b0 && w < 40 * p) begin @(negedge clk); w++; end
    if (tx !== 1'b0) ok = 0;
    repeat (p / 2) @(negedge clk);
    if (tx !== 1'b0) ok = 0;
    for (int i = 0; i < 8; i++) begin repeat (p) @(negedge clk); d[i] = tx; end
    if (par[1]) begin repeat (p) @(negedge clk); if (tx !== pbit(d, par)) ok = 0; end
    repeat (p) @(negedge clk);
    if (tx !== 1'b1) ok = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    summary;
  end

  initial begin
    logic [15:0] v;
    logic [7:0] cap [5];
    logic okv [5];
    logic [7:0] d;
    logic ok;
    int lows;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1;

    rd(2'd2, v); chk("R1 reset status", v, 16'h8000);
    chk("R1 tx idle", {15'd0, tx}, 16'd1);

    send(8'hA5, 0, 2'b00, 0, 0);
    rd(2'd2, v); chk("R1/R2 default rate status", v, 16'h8100);
    rd(2'd0, v); chk("R1/R2 default rate data", v, 16'hA500);
    rd(2'd2, v); chk("R6 empty after pop", v, 16'h8000);

    wr(2'd1, cfgw(8, 2'b00, 0));
    for (int i = 1; i <= 5; i++) send(8'(i * 8'h11), 8, 2'b00, 0, 0);
    rd(2'd2, v); chk("R7 full and overflow status", v, 16'h8700);
    for (int i = 1; i <= 4; i++) begin
      rd(2'd0, v); chk("R6/R7 queue order kept", v, {8'(i * 8'h11), 8'h00});
    end
    rd(2'd2, v); chk("R10 overflow cleared by read", v, 16'h8000);

    wr(2'd1, cfgw(7, 2'b00, 0));
    fork
      for (int k = 0; k < 5; k++) begin txget(7, 2'b00, cap[k], okv[k]); end
      begin
        for (int k = 0; k < 6; k++) wr(2'd0, {8'(8'hC0 + k), 8'h00});
        rd(2'd2, v); chk("R8 tx full and busy", v, 16'h9800);
      end
    join
    for (int k = 0; k < 5; k++) begin
      chk("R8/R3 tx order", {8'h00, cap[k]}, {8'h00, 8'(8'hC0 + k)});
      chk("R3 tx framing", {15'd0, okv[k]}, 16'd1);
    end
    repeat (bitp(7) * 2) @(negedge clk);
    rd(2'd2, v); chk("R8 sixth write dropped, idle", v, 16'h8000);

    wr(2'd1, cfgw(8, 2'b10, 1));
    rx = 0;
    lows = 0;
    fork
      for (int c = 0; c < 400; c++) begin @(negedge clk); if (tx !== 1'b1) lows++; end
      wr(2'd0, 16'h3C00);
    join
    chk("R5 tx pin held high", 16'(lows), 16'd0);
    rd(2'd2, v); chk("R5 looped char status", v, 16'h8100);
    rd(2'd0, v); chk("R5 looped char data", v, 16'h3C00);
    rx = 1;
    wr(2'd1, cfgw(8, 2'b00, 0));
    rd(2'd2, v); chk("R5 rx pin ignored", v, 16'h8000);

    for (int it = 0; it < 20; it++) begin
      int idx = 6 + int'($urandom % 3);
      logic [1:0] par = 2'($urandom % 4);
      logic badp = par[1] && ($urandom % 3 == 0);
      logic bads = ($urandom % 4 == 0);
      logic [7:0] dr = 8'($urandom);
      logic [7:0] dt = 8'($urandom);
      wr(2'd1, cfgw(idx, par, 0));
      send(dr, idx, par, badp, bads);
      rd(2'd2, v);
      chk("R2/R4/R9 rx status", v, 16'h8100 | (badp ? 16'h2000 : 16'h0) | (bads ? 16'h4000 : 16'h0));
      rd(2'd0, v); chk("R3/R2 rx data", v, {dr, 8'h00});
      rd(2'd2, v); chk("R10 errors cleared", v, 16'h8000);
      fork
        txget(idx, par, d, ok);
        wr(2'd0, {dt, 8'h00});
      join
      chk("R2/R3 tx data", {8'h00, d}, {8'h00, dt});
      chk("R4 tx parity and stop", {15'd0, ok}, 16'd1);
      repeat (bitp(idx) * 2) @(negedge clk);
    end
    summary;
  end
endmodule